// File: doc/BRIEF.md
# Memory Bus Cycle Engine

This block sits between an internal requester and a slow external memory. The requester raises a request carrying an address, an access size, write data and a write flag. The engine turns that request into a bus cycle on separate address, data, read-strobe and write-strobe lines. It then returns a single acknowledge pulse, together with the read data and an error flag. A bus cycle takes three clocks when no wait states are added. The memory adds wait states by holding its ready input low.

Reads and writes use the three clocks in different orders. A read presents the address with the read strobe, waits for the memory, and then takes the data in its third clock with the strobe already low. A write presents the address with the write strobe and puts the data on the bus one clock later. It then waits in its third clock until the memory is ready. Every request is checked for natural alignment against its size. A strict-mode input decides what happens to a misaligned request. In strict mode it is refused at once with an error. Otherwise it is carried out, and a misaligned full-width read becomes two aligned bus reads whose bytes are put back together in little-endian order.

Top module: `busmst_engine`

## Requirements
- R1: A read asserts `bus_rd_o` with the request address in its first clock. The strobe stays high through the waiting phase and is low in the third clock, and `bus_wdata_o` stays zero for the whole read. With no wait states, `ack_o` goes high in the fourth clock after the clock edge that accepts the request, and `rdata_o` then carries the bus word sampled in the third clock.
- R2: A write asserts `bus_wr_o` with the address in its first clock while `bus_wdata_o` is still zero. It drives the write data from the second clock onward and holds the strobe through the third clock. `ack_o` follows in the clock after the strobe drops.
- R3: A read waits in its second clock, and a write waits in its third clock. In either case the engine stays in that phase for every clock that `bus_ready_i` is sampled low, and moves on at the first clock edge where it is high. `bus_ready_i` has no effect in any other phase.
- R4: `req_size_i` encodes the access width: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes and 3 is 8 bytes. A request is misaligned when any of its lowest `req_size_i` address bits is 1.
- R5: When `strict_align_i` is 1, a misaligned request gets `ack_o` and `err_o` both high in the clock after it is accepted, and produces no strobe.
- R6: When `strict_align_i` is 0, a misaligned request is accepted. Apart from the case in R7, it runs as one ordinary bus cycle at the request address, with `bus_size_o` set to the request size.
- R7: When `strict_align_i` is 0, a misaligned 4-byte read (size code 2) becomes two reads: the first at the address with its low two bits cleared, the second 4 bytes above it. The read strobe is low for at least one clock between them. `rdata_o` is the 64-bit value {second word, first word} shifted right by 8 times the address's low two bits, keeping its low 32 bits.
- R8: `ack_o` is high for exactly one clock. `err_o` is 0 for any request that ran on the bus. A request that is still held high in the clock of its acknowledge is not accepted a second time.
- R9: The two strobes are never high together. `bus_addr_o` does not change while a strobe stays high. During the two reads of R7, `bus_size_o` shows code 2.
- R10: During and right after reset, both strobes, `ack_o`, `bus_addr_o` and `bus_wdata_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| strict_align_i | input | 1 | 1 refuses misaligned requests, 0 carries them out |
| req_i | input | 1 | Request, held high until acknowledged |
| req_we_i | input | 1 | 1 for a write, 0 for a read |
| req_size_i | input | SIZE_W (2) | Access size code (R4) |
| req_addr_i | input | ADDR_W (16) | Byte address |
| req_wdata_i | input | DATA_W (32) | Write data |
| ack_o | output | 1 | One-clock completion pulse |
| err_o | output | 1 | Alignment refusal, valid with `ack_o` |
| rdata_o | output | DATA_W (32) | Read result, valid with `ack_o` |
| bus_addr_o | output | ADDR_W (16) | Bus address |
| bus_size_o | output | SIZE_W (2) | Bus access size code |
| bus_rd_o | output | 1 | Read strobe |
| bus_wr_o | output | 1 | Write strobe |
| bus_wdata_o | output | DATA_W (32) | Bus write data, zero when not driven |
| bus_rdata_i | input | DATA_W (32) | Bus read data |
| bus_ready_i | input | 1 | Memory ready, low to insert wait states |

## Verification
The assertions check the bus rules on every clock. They cover strobe exclusion, a steady address under a strobe, a strobe held while ready is low and a read strobe released after ready, zero data in the first write clock, a one-clock acknowledge that never overlaps a strobe, and no bus activity around a refusal. Only the bench scenarios can show the rest. These are the exact latency for each wait count, which phase absorbs the wait, the contents of the returned and written words, the two aligned addresses of a split read and the byte reassembly of each offset, and the way the strict-mode input sorts requests by size and address.

// File: rtl/busmst_pkg.sv
`timescale 1ns/1ps
package busmst_pkg;

   // Phase of the current bus cycle. A read waits in PH_TWO, a write waits in PH_THREE.
   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_ONE   = 2'd1,
      PH_TWO   = 2'd2,
      PH_THREE = 2'd3
   } phase_t;

endpackage

// File: rtl/busmst_align_chk.sv
`timescale 1ns/1ps
// Natural alignment test: the address bits below the access size must be zero.
module busmst_align_chk #(
   parameter int SIZE_W = 2,
   parameter int LOW_W  = 3
) (
   input  logic [SIZE_W-1:0] size_i,
   input  logic [LOW_W-1:0]  addr_low_i,
   output logic              misaligned_o
);
   logic [LOW_W-1:0] mask;

   always_comb begin
      for (int i = 0; i < LOW_W; i++) begin
         mask[i] = (int'(size_i) > i);
      end
   end

   assign misaligned_o = |(addr_low_i & mask);
endmodule

// File: rtl/busmst_merge.sv
`timescale 1ns/1ps
// Little-endian reassembly of two adjacent bus words.
module busmst_merge #(
   parameter int DATA_W = 32,
   parameter int OFF_W  = 2
) (
   input  logic [DATA_W-1:0] lo_i,
   input  logic [DATA_W-1:0] hi_i,
   input  logic [OFF_W-1:0]  off_i,
   output logic [DATA_W-1:0] data_o
);
   localparam int PAIR_W = 2 * DATA_W;

   logic [PAIR_W-1:0] pair;
   logic [PAIR_W-1:0] shifted;

   always_comb begin
      pair    = {hi_i, lo_i};
      shifted = pair >> (8 * int'(off_i));
      data_o  = shifted[DATA_W-1:0];
   end
endmodule

// File: rtl/busmst_seq.sv
`timescale 1ns/1ps
// Bus phase sequencer: request capture, phase walk, wait handling, split reads.
module busmst_seq
   import busmst_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 32,
   parameter int SIZE_W = 2,
   parameter int OFF_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic              req_we_i,
   input  logic [SIZE_W-1:0] req_size_i,
   input  logic [ADDR_W-1:0] req_addr_i,
   input  logic [DATA_W-1:0] req_wdata_i,
   input  logic              misal_i,
   input  logic              strict_i,
   input  logic              bus_ready_i,
   input  logic [DATA_W-1:0] bus_rdata_i,
   input  logic [DATA_W-1:0] merged_i,
   output logic              ack_o,
   output logic              err_o,
   output logic [DATA_W-1:0] rdata_o,
   output logic [ADDR_W-1:0] bus_addr_o,
   output logic [SIZE_W-1:0] bus_size_o,
   output logic              bus_rd_o,
   output logic              bus_wr_o,
   output logic [DATA_W-1:0] bus_wdata_o,
   output logic [DATA_W-1:0] lo_word_o,
   output logic [OFF_W-1:0]  offset_o
);
   localparam logic [ADDR_W-1:0] STEP      = ADDR_W'(DATA_W / 8);
   localparam logic [SIZE_W-1:0] FULL_SIZE = SIZE_W'(OFF_W);

   phase_t            phase_q;
   logic              we_q, split_q, upper_q, ack_q, err_q;
   logic [ADDR_W-1:0] addr_q;
   logic [SIZE_W-1:0] size_q;
   logic [DATA_W-1:0] wdata_q, rdata_q, lo_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         we_q    <= 1'b0;
         split_q <= 1'b0;
         upper_q <= 1'b0;
         ack_q   <= 1'b0;
         err_q   <= 1'b0;
         addr_q  <= '0;
         size_q  <= '0;
         wdata_q <= '0;
         rdata_q <= '0;
         lo_q    <= '0;
      end else begin
         ack_q <= 1'b0;
         err_q <= 1'b0;
         unique case (phase_q)
            PH_IDLE: begin
               if (req_i && !ack_q) begin
                  if (misal_i && strict_i) begin
                     ack_q   <= 1'b1;
                     err_q   <= 1'b1;
                     rdata_q <= '0;
                  end else begin
                     we_q    <= req_we_i;
                     addr_q  <= req_addr_i;
                     size_q  <= req_size_i;
                     wdata_q <= req_wdata_i;
                     split_q <= misal_i && !req_we_i && (req_size_i == FULL_SIZE);
                     upper_q <= 1'b0;
                     phase_q <= PH_ONE;
                  end
               end
            end
            PH_ONE: phase_q <= PH_TWO;
            PH_TWO: begin
               if (we_q || bus_ready_i) phase_q <= PH_THREE;
            end
            PH_THREE: begin
               if (we_q) begin
                  if (bus_ready_i) begin
                     ack_q   <= 1'b1;
                     rdata_q <= '0;
                     phase_q <= PH_IDLE;
                  end
               end else if (split_q && !upper_q) begin
                  lo_q    <= bus_rdata_i;
                  upper_q <= 1'b1;
                  phase_q <= PH_ONE;
               end else begin
                  rdata_q <= split_q ? merged_i : bus_rdata_i;
                  ack_q   <= 1'b1;
                  phase_q <= PH_IDLE;
               end
            end
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   logic              active;
   logic [ADDR_W-1:0] base;

   always_comb begin
      active      = (phase_q != PH_IDLE);
      base        = {addr_q[ADDR_W-1:OFF_W], OFF_W'(0)};
      bus_rd_o    = active && !we_q && (phase_q != PH_THREE);
      bus_wr_o    = active && we_q;
      bus_wdata_o = (bus_wr_o && (phase_q != PH_ONE)) ? wdata_q : '0;
      if (!active)      bus_addr_o = '0;
      else if (split_q) bus_addr_o = upper_q ? base + STEP : base;
      else              bus_addr_o = addr_q;
      if (!active)      bus_size_o = '0;
      else if (split_q) bus_size_o = FULL_SIZE;
      else              bus_size_o = size_q;
   end

   assign ack_o     = ack_q;
   assign err_o     = err_q;
   assign rdata_o   = rdata_q;
   assign lo_word_o = lo_q;
   assign offset_o  = addr_q[OFF_W-1:0];
endmodule

// File: rtl/busmst_engine.sv
`timescale 1ns/1ps
// Memory bus cycle engine: top level.
module busmst_engine #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 32,
   parameter int SIZE_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strict_align_i,
   input  logic              req_i,
   input  logic              req_we_i,
   input  logic [SIZE_W-1:0] req_size_i,
   input  logic [ADDR_W-1:0] req_addr_i,
   input  logic [DATA_W-1:0] req_wdata_i,
   output logic              ack_o,
   output logic              err_o,
   output logic [DATA_W-1:0] rdata_o,
   output logic [ADDR_W-1:0] bus_addr_o,
   output logic [SIZE_W-1:0] bus_size_o,
   output logic              bus_rd_o,
   output logic              bus_wr_o,
   output logic [DATA_W-1:0] bus_wdata_o,
   input  logic [DATA_W-1:0] bus_rdata_i,
   input  logic              bus_ready_i
);
   localparam int LANES = DATA_W / 8;
   localparam int OFF_W = $clog2(LANES);
   localparam int LOW_W = 3;

   generate
      if (DATA_W != 16 && DATA_W != 32 && DATA_W != 64) begin : g_bad_data_w
         $error("busmst_engine: DATA_W must be 16, 32 or 64");
      end
      if (ADDR_W < LOW_W + 1) begin : g_bad_addr_w
         $error("busmst_engine: ADDR_W too small");
      end
      if (SIZE_W != 2) begin : g_bad_size_w
         $error("busmst_engine: SIZE_W must be 2");
      end
   endgenerate

   logic              misal;
   logic [DATA_W-1:0] lo_word, merged;
   logic [OFF_W-1:0]  offset;

   busmst_align_chk #(.SIZE_W(SIZE_W), .LOW_W(LOW_W)) u_align (
      .size_i       (req_size_i),
      .addr_low_i   (req_addr_i[LOW_W-1:0]),
      .misaligned_o (misal)
   );

   busmst_merge #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_merge (
      .lo_i   (lo_word),
      .hi_i   (bus_rdata_i),
      .off_i  (offset),
      .data_o (merged)
   );

   busmst_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIZE_W(SIZE_W), .OFF_W(OFF_W)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_i       (req_i),
      .req_we_i    (req_we_i),
      .req_size_i  (req_size_i),
      .req_addr_i  (req_addr_i),
      .req_wdata_i (req_wdata_i),
      .misal_i     (misal),
      .strict_i    (strict_align_i),
      .bus_ready_i (bus_ready_i),
      .bus_rdata_i (bus_rdata_i),
      .merged_i    (merged),
      .ack_o       (ack_o),
      .err_o       (err_o),
      .rdata_o     (rdata_o),
      .bus_addr_o  (bus_addr_o),
      .bus_size_o  (bus_size_o),
      .bus_rd_o    (bus_rd_o),
      .bus_wr_o    (bus_wr_o),
      .bus_wdata_o (bus_wdata_o),
      .lo_word_o   (lo_word),
      .offset_o    (offset)
   );
endmodule

// File: rtl/busmst_engine_chk.sv
`timescale 1ns/1ps
// Protocol checker, bound to every busmst_engine instance.
module busmst_engine_chk #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 32,
   parameter int SIZE_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ack_o,
   input logic              err_o,
   input logic [ADDR_W-1:0] bus_addr_o,
   input logic [SIZE_W-1:0] bus_size_o,
   input logic              bus_rd_o,
   input logic              bus_wr_o,
   input logic [DATA_W-1:0] bus_wdata_o,
   input logic              bus_ready_i
);
   p_strobe_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_rd_o && bus_wr_o));

   p_addr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ((bus_rd_o || bus_wr_o) && $past(bus_rd_o || bus_wr_o)) |-> $stable(bus_addr_o));

   p_rd_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd_o && !bus_ready_i) |=> bus_rd_o);

   p_rd_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd_o && $past(bus_rd_o) && bus_ready_i) |=> !bus_rd_o);

   p_wr_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr_o && !bus_ready_i) |=> bus_wr_o);

   p_wr_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_wr_o) |-> (bus_wdata_o == '0));

   p_wr_min_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_wr_o) |=> bus_wr_o);

   p_ack_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ack_o |=> !ack_o);

   p_ack_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ack_o |-> (!bus_rd_o && !bus_wr_o));

   p_err_nobus_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_o && err_o) |-> ($past(!bus_rd_o && !bus_wr_o) && $past(bus_size_o) == '0));

   p_rd_nodata_r1: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd_o |-> (bus_wdata_o == '0));
endmodule

bind busmst_engine busmst_engine_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIZE_W(SIZE_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ack_o       (ack_o),
   .err_o       (err_o),
   .bus_addr_o  (bus_addr_o),
   .bus_size_o  (bus_size_o),
   .bus_rd_o    (bus_rd_o),
   .bus_wr_o    (bus_wr_o),
   .bus_wdata_o (bus_wdata_o),
   .bus_ready_i (bus_ready_i)
);

// File: tb/busmst_engine_tb_top.sv
`timescale 1ns/1ps
module busmst_engine_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        strict = 1'b0, req = 1'b0, req_we = 1'b0;
   logic [1:0]  req_size = '0;
   logic [15:0] req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic        ack, err;
   logic [31:0] rdata, bus_wdata, bus_rdata;
   logic [15:0] bus_addr;
   logic [1:0]  bus_size;
   logic        bus_rd, bus_wr;
   logic        ready = 1'b0;

   int errors = 0;
   int checks = 0;

   always #2.5 clk = ~clk;

   busmst_engine dut_i (
      .clk(clk), .rst_n(rst_n), .strict_align_i(strict), .req_i(req),
      .req_we_i(req_we), .req_size_i(req_size), .req_addr_i(req_addr),
      .req_wdata_i(req_wdata), .ack_o(ack), .err_o(err), .rdata_o(rdata),
      .bus_addr_o(bus_addr), .bus_size_o(bus_size), .bus_rd_o(bus_rd),
      .bus_wr_o(bus_wr), .bus_wdata_o(bus_wdata), .bus_rdata_i(bus_rdata),
      .bus_ready_i(ready)
   );

   // Slave memory and a separate expectation copy.
   logic [31:0] mem     [0:255];
   logic [31:0] exp_mem [0:255];

   function automatic logic [31:0] seed_word(input int i);
      logic [7:0] b;
      b = 8'(i);
      return {b ^ 8'h5A, b + 8'd1, ~b, b};
   endfunction

   assign bus_rdata = mem[bus_addr[9:2]];

   // Slave monitor: ready timing, write commit, per-transaction bus record.
   int          hold_n = 0;
   int          idx = 0;
   int          nruns = 0;
   int          run_len [2];
   logic [15:0] run_addr [2];
   logic [1:0]  size_seen;
   logic [31:0] exp_wd;
   bit          both_bad, addr_bad, wd_first_nz, wd_later_bad;

   always @(negedge clk) begin
      if (!rst_n) begin
         idx   = 0;
         ready = 1'b0;
      end else if (bus_rd || bus_wr) begin
         if (bus_rd && bus_wr) both_bad = 1'b1;
         if (idx == 0) begin
            if (nruns < 2) run_addr[nruns] = bus_addr;
            size_seen = bus_size;
            if (bus_wr && bus_wdata != 32'd0) wd_first_nz = 1'b1;
         end else begin
            if (nruns < 2 && bus_addr != run_addr[nruns]) addr_bad = 1'b1;
            if (bus_wr && bus_wdata != exp_wd) wd_later_bad = 1'b1;
         end
         ready = (idx >= hold_n);
         if (bus_wr && ready && idx >= 2) mem[bus_addr[9:2]] = bus_wdata;
         idx++;
      end else begin
         if (idx != 0) begin
            if (nruns < 2) run_len[nruns] = idx;
            nruns++;
         end
         idx   = 0;
         ready = 1'b0;
      end
   end

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   function automatic bit misal_f(input logic [1:0] sz, input logic [15:0] a);
      logic [2:0] m;
      m = 3'((1 << sz) - 1);
      return (a[2:0] & m) != 3'd0;
   endfunction

   function automatic int max_i(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   task automatic do_txn(input bit we, input logic [1:0] sz, input logic [15:0] a,
                         input logic [31:0] wd, input bit st, input int h,
                         input bit hold_extra);
      bit          e_err, e_split, mis;
      int          e_runs, e_len, e_lat, lat;
      logic [31:0] e_rd;
      logic [15:0] base;
      logic [63:0] pair;
      string       tl;

      mis     = misal_f(sz, a);
      e_err   = mis && st;
      e_split = mis && !st && !we && (sz == 2'd2);
      base    = {a[15:2], 2'b00};
      e_len   = we ? max_i(3, h + 1) : max_i(2, h + 1);
      if (e_err) begin
         e_runs = 0; e_lat = 1; e_rd = '0; tl = "R5";
      end else if (e_split) begin
         e_runs = 2; e_lat = 2 * (e_len + 1) + 1; tl = "R7";
         pair   = {exp_mem[base[9:2] + 8'd1], exp_mem[base[9:2]]};
         pair   = pair >> (8 * a[1:0]);
         e_rd   = pair[31:0];
      end else if (we) begin
         e_runs = 1; e_lat = e_len + 1; e_rd = '0; tl = "R2";
      end else begin
         e_runs = 1; e_lat = e_len + 2; e_rd = exp_mem[a[9:2]]; tl = "R1";
      end

      @(negedge clk);
      #1;
      check(!ack, "R8", "ack low before request", 64'(ack), 64'd0);
      nruns = 0; both_bad = 0; addr_bad = 0; wd_first_nz = 0; wd_later_bad = 0;
      hold_n = h; exp_wd = wd;
      strict = st; req_we = we; req_size = sz; req_addr = a; req_wdata = wd;
      req = 1'b1;
      lat = 0;
      do begin
         @(posedge clk);
         lat++;
         @(negedge clk);
      end while (!ack && lat < 200);
      #1;
      check(lat == e_lat, tl, "ack latency", 64'(lat), 64'(e_lat));
      check(err == e_err, "R4", "error flag", 64'(err), 64'(e_err));
      if (!we && !e_err)
         check(rdata == e_rd, tl, "read data", 64'(rdata), 64'(e_rd));
      if (hold_extra) begin
         @(posedge clk);
         @(negedge clk);
         #1;
         check(!ack && !bus_rd && !bus_wr, "R8", "held request re-accepted",
               64'({ack, bus_rd, bus_wr}), 64'd0);
      end
      req = 1'b0;
      check(nruns == e_runs, (mis && !st) ? "R6" : tl, "bus cycle count",
            64'(nruns), 64'(e_runs));
      if (e_runs >= 1 && nruns >= 1) begin
         check(run_len[0] == e_len, "R3", "strobe length", 64'(run_len[0]), 64'(e_len));
         check(run_addr[0] == (e_split ? base : a), e_split ? "R7" : "R6",
               "first bus address", 64'(run_addr[0]), 64'(e_split ? base : a));
         check(size_seen == sz, "R9", "bus size", 64'(size_seen), 64'(sz));
      end
      if (e_runs == 2 && nruns == 2) begin
         check(run_len[1] == e_len, "R3", "second strobe length", 64'(run_len[1]), 64'(e_len));
         check(run_addr[1] == base + 16'd4, "R7", "second bus address",
               64'(run_addr[1]), 64'(base + 16'd4));
      end
      if (we && !e_err) begin
         check(!wd_first_nz, "R2", "data in first write clock", 64'(wd_first_nz), 64'd0);
         check(!wd_later_bad, "R2", "write data on bus", 64'(wd_later_bad), 64'd0);
         exp_mem[a[9:2]] = wd;
      end
      check(!both_bad && !addr_bad, "R9", "strobe overlap or address change",
            64'({both_bad, addr_bad}), 64'd0);
   endtask

   task automatic summary;
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      for (int i = 0; i < 256; i++) begin
         mem[i]     = seed_word(i);
         exp_mem[i] = seed_word(i);
      end
      void'($urandom(32'd4711));
      repeat (4) @(negedge clk);
      #1;
      check(!bus_rd && !bus_wr && !ack && bus_addr == 16'd0 && bus_wdata == 32'd0,
            "R10", "reset outputs", 64'({bus_rd, bus_wr, ack, bus_addr, bus_wdata}), 64'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      #1;
      check(!bus_rd && !bus_wr && !ack, "R10", "idle after reset",
            64'({bus_rd, bus_wr, ack}), 64'd0);

      // Directed corner cases.
      do_txn(1'b0, 2'd2, 16'h0040, 32'h0, 1'b1, 0, 1'b0);   // R1 plain read, no waits
      do_txn(1'b0, 2'd2, 16'h0044, 32'h0, 1'b1, 4, 1'b0);   // R3 read with waits
      do_txn(1'b1, 2'd2, 16'h0080, 32'hCAFE_0001, 1'b1, 0, 1'b0); // R2 write, no waits
      do_txn(1'b1, 2'd2, 16'h0084, 32'hCAFE_0002, 1'b1, 5, 1'b1); // R2 R3 R8 write, waits, held req
      do_txn(1'b0, 2'd2, 16'h0080, 32'h0, 1'b1, 1, 1'b0);   // R2 read back
      do_txn(1'b0, 2'd2, 16'h0084, 32'h0, 1'b1, 2, 1'b0);
      do_txn(1'b0, 2'd1, 16'h0011, 32'h0, 1'b1, 0, 1'b0);   // R5 strict refuse 2-byte
      do_txn(1'b0, 2'd2, 16'h0012, 32'h0, 1'b1, 0, 1'b0);   // R5 strict refuse 4-byte
      do_txn(1'b1, 2'd3, 16'h0014, 32'h1, 1'b1, 0, 1'b1);   // R5 strict refuse 8-byte write
      do_txn(1'b0, 2'd3, 16'h0018, 32'h0, 1'b1, 0, 1'b0);   // R4 aligned 8-byte accepted
      do_txn(1'b0, 2'd0, 16'h0017, 32'h0, 1'b1, 0, 1'b0);   // R4 byte never misaligned
      for (int o = 1; o < 4; o++)                           // R7 split, every offset
         do_txn(1'b0, 2'd2, 16'h0100 + 16'(o), 32'h0, 1'b0, o, 1'b0);
      do_txn(1'b0, 2'd1, 16'h0121, 32'h0, 1'b0, 2, 1'b0);   // R6 soft 2-byte single cycle
      do_txn(1'b1, 2'd2, 16'h0132, 32'h1234_5678, 1'b0, 1, 1'b0); // R6 soft misaligned write
      do_txn(1'b0, 2'd2, 16'h0130, 32'h0, 1'b0, 0, 1'b0);

      // Random mix.
      for (int n = 0; n < 160; n++) begin
         do_txn(($urandom % 3) == 0, 2'($urandom % 4), 16'($urandom % 1016),
                $urandom, 1'($urandom % 2), int'($urandom % 5), ($urandom % 8) == 0);
      end

      summary();
      $finish;
   end
endmodule